// File: doc/BRIEF.md
# Critical-Word-First Cache Line Refill Controller

This block runs the refill of one cache line after a miss. The line holds four 64-bit double words. The bus returns the double word that holds the missed address first. The other three follow in wrapping order. Each beat goes straight to the unit that missed, either the instruction fetcher or the load/store unit, in the same cycle it appears on the bus. That unit can restart before the whole line is present.

Beats are collected in a staging buffer, one slot per double word. Once the fourth beat is in, the whole line goes to the cache array in a single write. Every byte of every beat is checked against its parity bit. If any beat fails, the cache write is dropped and the requester gets an error pulse in its place. Only one refill runs at a time. Bus arbitration and tag lookup belong to other blocks.

Top module: `cwf_line_fill`

## Requirements
- R1: The first beat of a refill is forwarded with `fwd_first` = 1, and `fwd_idx` equals the critical index `req_addr[4:3]`.
- R2: Beat number k (k = 0..3) of a refill belongs to double-word slot (critical index + k) mod 4. `fwd_idx` reports that slot, and the beat is stored at `cwr_line[64*slot +: 64]`.
- R3: A beat is forwarded, with `fwd_data` equal to `bus_data`, in the same cycle that `bus_valid` is high during a refill. `cwr_valid` rises in the cycle after the fourth beat, which is after every forward, and lasts one cycle.
- R4: When `req_src` is 0 (fetcher), forwards and errors appear on `ifu_fwd_valid` and `ifu_fill_err`. When `req_src` is 1 (load/store), they appear on `lsu_fwd_valid` and `lsu_fill_err`. The two sides are never active together.
- R5: Parity is even per byte: `bus_par[b]` must equal the XOR of `bus_data[8b+7:8b]`. A mismatch in any byte marks that beat as bad.
- R6: On a clean refill, `cwr_addr` is the request address with bits [4:0] cleared, and `cwr_line` holds the four received double words in slot order.
- R7: `req_ready` is high only when no refill is running, including its write cycle. A request presented while `req_ready` is low is ignored: the address, requester and beat order of the refill in progress are unchanged.
- R8: If any beat of a refill had a parity error, `cwr_valid` stays low for that refill. Instead, the requester's error output pulses for one cycle in the write cycle.
- R9: `bus_valid` while no refill is running causes no forward, no cache write and no change of state.
- R10: From the cycle after acceptance until the write cycle, `bus_addr` equals the request address with bits [2:0] cleared.
- R11: After reset, `req_ready` is 1 and every valid and error output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request present |
| req_addr | input | 32 | Byte address of the miss |
| req_src | input | 1 | Requester: 0 fetcher, 1 load/store |
| req_ready | output | 1 | Controller idle, request will be taken |
| bus_addr | output | 32 | Double-word-aligned address of the critical word |
| bus_valid | input | 1 | Data beat present on the bus |
| bus_data | input | 64 | Beat data |
| bus_par | input | 8 | Even parity, one bit per byte |
| ifu_fwd_valid | output | 1 | Beat forwarded to the fetcher |
| lsu_fwd_valid | output | 1 | Beat forwarded to the load/store unit |
| fwd_data | output | 64 | Forwarded double word |
| fwd_idx | output | 2 | Slot of the forwarded double word in the line |
| fwd_first | output | 1 | Forwarded beat is the critical one |
| ifu_fill_err | output | 1 | Refill for the fetcher failed parity |
| lsu_fill_err | output | 1 | Refill for the load/store unit failed parity |
| cwr_valid | output | 1 | Full-line cache write |
| cwr_addr | output | 32 | Line-aligned write address |
| cwr_line | output | 256 | Line data, slot 0 in the low bits |

## Verification
The bound checker runs on every cycle. It checks that forwards reach only one requester, that the first forward carries the critical index, and that the cache write is a one-cycle pulse preceded by a forward. It also checks that an error and a write never coincide, and that addresses hold while a refill is running. The wrapping slot order of later beats, the exact data placed in each slot, and parity detection on particular bytes are shown only by the bench's scenarios. Those scenarios compare every forward and every finished line with a model line. The same goes for ignoring of requests and beats at the wrong time.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_FILL  = 2'd1,
    FS_WRITE = 2'd2
  } fill_state_e;

  typedef enum logic {
    SRC_FETCH = 1'b0,
    SRC_LSU   = 1'b1
  } req_src_e;
endpackage

// File: rtl/cwf_parity_chk.sv
module cwf_parity_chk #(
  parameter int DATA_W = 64,
  parameter int PAR_W  = DATA_W / 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic [PAR_W-1:0]  par,
  output logic              perr
);
  logic [PAR_W-1:0] byte_bad;

  for (genvar b = 0; b < PAR_W; b++) begin : g_byte
    assign byte_bad[b] = par[b] ^ (^data[b*8 +: 8]);
  end

  assign perr = |byte_bad;
endmodule

// File: rtl/cwf_fill_seq.sv
module cwf_fill_seq
  import cwf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BEATS  = 4,
  parameter int OFS_W  = 3,
  parameter int IDX_W  = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_src,
  input  logic              bus_valid,
  input  logic              beat_perr,
  output logic              req_ready,
  output logic              beat_fire,
  output logic [IDX_W-1:0]  beat_slot,
  output logic              beat_first,
  output logic              wr_phase,
  output logic              fill_err,
  output req_src_e          src_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [IDX_W-1:0]  crit_idx,
  output logic [IDX_W-1:0]  beat_cnt
);
  fill_state_e st;

  function automatic logic [IDX_W-1:0] crit_of(input logic [ADDR_W-1:0] a);
    return a[OFS_W +: IDX_W];
  endfunction

  function automatic logic [IDX_W-1:0] slot_of(input logic [IDX_W-1:0] c,
                                               input logic [IDX_W-1:0] k);
    int s;
    s = (int'(c) + int'(k)) % BEATS;
    return IDX_W'(s);
  endfunction

  logic accept, last_beat;

  assign req_ready  = (st == FS_IDLE);
  assign accept     = req_ready && req_valid;
  assign beat_fire  = (st == FS_FILL) && bus_valid;
  assign beat_slot  = slot_of(crit_idx, beat_cnt);
  assign beat_first = beat_fire && (beat_cnt == '0);
  assign last_beat  = (beat_cnt == IDX_W'(BEATS - 1));
  assign wr_phase   = (st == FS_WRITE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= FS_IDLE;
      beat_cnt <= '0;
      crit_idx <= '0;
      addr_q   <= '0;
      src_q    <= SRC_FETCH;
      fill_err <= 1'b0;
    end else begin
      unique case (st)
        FS_IDLE: begin
          if (accept) begin
            st       <= FS_FILL;
            addr_q   <= req_addr;
            crit_idx <= crit_of(req_addr);
            src_q    <= req_src_e'(req_src);
            beat_cnt <= '0;
            fill_err <= 1'b0;
          end
        end
        FS_FILL: begin
          if (bus_valid) begin
            fill_err <= fill_err | beat_perr;
            beat_cnt <= beat_cnt + 1'b1;
            if (last_beat) st <= FS_WRITE;
          end
        end
        FS_WRITE: st <= FS_IDLE;
        default:  st <= FS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cwf_line_buf.sv
module cwf_line_buf #(
  parameter int DATA_W = 64,
  parameter int BEATS  = 4,
  parameter int IDX_W  = $clog2(BEATS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [IDX_W-1:0]        widx,
  input  logic [DATA_W-1:0]       wdata,
  output logic [BEATS*DATA_W-1:0] line
);
  for (genvar s = 0; s < BEATS; s++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                            slot_q <= '0;
      else if (we && (widx == IDX_W'(s)))    slot_q <= wdata;
    end
    assign line[s*DATA_W +: DATA_W] = slot_q;
  end
endmodule

// File: rtl/cwf_line_fill.sv
module cwf_line_fill
  import cwf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int BEATS  = 4,
  localparam int PAR_W    = DATA_W / 8,
  localparam int OFS_W    = $clog2(PAR_W),
  localparam int IDX_W    = $clog2(BEATS),
  localparam int LINE_OFS = OFS_W + IDX_W,
  localparam int LINE_W   = BEATS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_src,
  output logic              req_ready,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_valid,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [PAR_W-1:0]  bus_par,
  output logic              ifu_fwd_valid,
  output logic              lsu_fwd_valid,
  output logic [DATA_W-1:0] fwd_data,
  output logic [IDX_W-1:0]  fwd_idx,
  output logic              fwd_first,
  output logic              ifu_fill_err,
  output logic              lsu_fill_err,
  output logic              cwr_valid,
  output logic [ADDR_W-1:0] cwr_addr,
  output logic [LINE_W-1:0] cwr_line
);
  function automatic logic [ADDR_W-1:0] align_down(input logic [ADDR_W-1:0] a,
                                                   input int lsb);
    logic [ADDR_W-1:0] m;
    m = '1;
    m = m << lsb;
    return a & m;
  endfunction

  // Named internal events for the checker
  logic              beat_fire, beat_perr, wr_phase, fill_err;
  logic [IDX_W-1:0]  beat_slot, crit_idx, beat_cnt;
  logic              beat_first;
  logic [ADDR_W-1:0] addr_q;
  req_src_e          src_q;

  cwf_parity_chk #(.DATA_W(DATA_W), .PAR_W(PAR_W)) u_par (
    .data (bus_data),
    .par  (bus_par),
    .perr (beat_perr)
  );

  cwf_fill_seq #(
    .ADDR_W(ADDR_W), .BEATS(BEATS), .OFS_W(OFS_W), .IDX_W(IDX_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_src    (req_src),
    .bus_valid  (bus_valid),
    .beat_perr  (beat_perr),
    .req_ready  (req_ready),
    .beat_fire  (beat_fire),
    .beat_slot  (beat_slot),
    .beat_first (beat_first),
    .wr_phase   (wr_phase),
    .fill_err   (fill_err),
    .src_q      (src_q),
    .addr_q     (addr_q),
    .crit_idx   (crit_idx),
    .beat_cnt   (beat_cnt)
  );

  cwf_line_buf #(.DATA_W(DATA_W), .BEATS(BEATS), .IDX_W(IDX_W)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (beat_fire),
    .widx  (beat_slot),
    .wdata (bus_data),
    .line  (cwr_line)
  );

  assign ifu_fwd_valid = beat_fire && (src_q == SRC_FETCH);
  assign lsu_fwd_valid = beat_fire && (src_q == SRC_LSU);
  assign fwd_data      = bus_data;
  assign fwd_idx       = beat_slot;
  assign fwd_first     = beat_first;

  assign cwr_valid    = wr_phase && !fill_err;
  assign ifu_fill_err = wr_phase && fill_err && (src_q == SRC_FETCH);
  assign lsu_fill_err = wr_phase && fill_err && (src_q == SRC_LSU);

  assign cwr_addr = align_down(addr_q, LINE_OFS);
  assign bus_addr = align_down(addr_q, OFS_W);
endmodule

// File: rtl/cwf_line_fill_chk.sv
module cwf_line_fill_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              ifu_fwd_valid,
  input logic              lsu_fwd_valid,
  input logic              fwd_first,
  input logic [IDX_W-1:0]  fwd_idx,
  input logic              cwr_valid,
  input logic [ADDR_W-1:0] cwr_addr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              ifu_fill_err,
  input logic              lsu_fill_err,
  input logic [IDX_W-1:0]  crit_idx
);
  logic any_fwd;
  assign any_fwd = ifu_fwd_valid || lsu_fwd_valid;

  p_single_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ifu_fwd_valid && lsu_fwd_valid));

  p_first_is_crit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (any_fwd && fwd_first) |-> (fwd_idx == crit_idx));

  p_write_after_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cwr_valid |-> $past(any_fwd));

  p_write_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cwr_valid |=> !cwr_valid);

  p_err_blocks_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ifu_fill_err || lsu_fill_err) |-> !cwr_valid);

  p_err_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ifu_fill_err, lsu_fill_err}));

  p_hold_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> ($stable(cwr_addr) && $stable(bus_addr)));

  p_fwd_only_in_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    any_fwd |-> !req_ready);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !(cwr_valid || ifu_fill_err || lsu_fill_err));
endmodule

bind cwf_line_fill cwf_line_fill_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .ifu_fwd_valid (ifu_fwd_valid),
  .lsu_fwd_valid (lsu_fwd_valid),
  .fwd_first     (fwd_first),
  .fwd_idx       (fwd_idx),
  .cwr_valid     (cwr_valid),
  .cwr_addr      (cwr_addr),
  .bus_addr      (bus_addr),
  .ifu_fill_err  (ifu_fill_err),
  .lsu_fill_err  (lsu_fill_err),
  .crit_idx      (crit_idx)
);

// File: tb/cwf_line_fill_test.sv
module cwf_line_fill_test;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam int NB = 4;
  localparam int PW = 8;
  localparam int IW = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic          req_src;
  logic          req_ready;
  logic [AW-1:0] bus_addr;
  logic          bus_valid;
  logic [DW-1:0] bus_data;
  logic [PW-1:0] bus_par;
  logic          ifu_fwd_valid, lsu_fwd_valid;
  logic [DW-1:0] fwd_data;
  logic [IW-1:0] fwd_idx;
  logic          fwd_first;
  logic          ifu_fill_err, lsu_fill_err;
  logic          cwr_valid;
  logic [AW-1:0] cwr_addr;
  logic [NB*DW-1:0] cwr_line;

  cwf_line_fill uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_src(req_src), .req_ready(req_ready), .bus_addr(bus_addr),
    .bus_valid(bus_valid), .bus_data(bus_data), .bus_par(bus_par),
    .ifu_fwd_valid(ifu_fwd_valid), .lsu_fwd_valid(lsu_fwd_valid),
    .fwd_data(fwd_data), .fwd_idx(fwd_idx), .fwd_first(fwd_first),
    .ifu_fill_err(ifu_fill_err), .lsu_fill_err(lsu_fill_err),
    .cwr_valid(cwr_valid), .cwr_addr(cwr_addr), .cwr_line(cwr_line)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] mem [NB];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [NB*DW-1:0] act, input logic [NB*DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int slot_for(input int crit, input int k);
    return (crit + k) & (NB - 1);
  endfunction

  function automatic logic [PW-1:0] even_par(input logic [DW-1:0] d);
    logic [PW-1:0] p;
    for (int b = 0; b < PW; b++) p[b] = ($countones(d[b*8 +: 8]) % 2) == 1;
    return p;
  endfunction

  function automatic logic [NB*DW-1:0] model_line();
    logic [NB*DW-1:0] l;
    for (int s = 0; s < NB; s++) l[s*DW +: DW] = mem[s];
    return l;
  endfunction

  // bad_beat < 0: no parity error; poke: foreign request during the refill
  task automatic do_fill(input logic [AW-1:0] a, input bit src, input int bad_beat,
                         input bit gaps, input bit poke);
    int crit;
    logic [AW-1:0] line_a, dw_a;
    crit   = int'(a[4:3]);
    line_a = {a[AW-1:5], 5'b0};
    dw_a   = {a[AW-1:3], 3'b0};
    for (int s = 0; s < NB; s++) mem[s] = {$urandom(), $urandom()};
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_src = src;
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(req_ready == 1'b0, "R7", "ready during fill", req_ready, 0);
    chk(bus_addr == dw_a, "R10", "bus_addr", bus_addr, dw_a);
    for (int k = 0; k < NB; k++) begin
      int sl;
      sl = slot_for(crit, k);
      if (gaps) begin
        int g;
        g = $urandom_range(0, 2);
        repeat (g) begin
          bus_valid = 1'b0;
          #1;
          chk(!(ifu_fwd_valid || lsu_fwd_valid), "R3", "forward in gap",
              {ifu_fwd_valid, lsu_fwd_valid}, 0);
          @(negedge clk);
        end
      end
      bus_valid = 1'b1;
      bus_data  = mem[sl];
      bus_par   = even_par(mem[sl]) ^ ((k == bad_beat) ? PW'(1 << (k % PW)) : PW'(0));
      if (poke && k == 1) begin
        req_valid = 1'b1; req_addr = a ^ 32'h0000_0120; req_src = ~src;
      end else begin
        req_valid = 1'b0;
      end
      #1;
      chk(ifu_fwd_valid == !src && lsu_fwd_valid == src, "R4", "forward target",
          {ifu_fwd_valid, lsu_fwd_valid}, {!src, src});
      chk(fwd_idx == IW'(sl), "R2", "forward slot", fwd_idx, sl);
      chk(fwd_data == mem[sl], "R3", "forward data", fwd_data, mem[sl]);
      chk(fwd_first == (k == 0), "R1", "first flag", fwd_first, (k == 0));
      chk(cwr_valid == 1'b0, "R3", "write before last beat", cwr_valid, 0);
      @(negedge clk);
    end
    bus_valid = 1'b0; req_valid = 1'b0;
    #1;
    if (bad_beat < 0) begin
      chk(cwr_valid == 1'b1, "R3", "write after last beat", cwr_valid, 1);
      chk(cwr_addr == line_a, "R6", "line address", cwr_addr, line_a);
      chk(cwr_line == model_line(), "R6", "line data", cwr_line, model_line());
      chk(!(ifu_fill_err || lsu_fill_err), "R8", "no error", {ifu_fill_err, lsu_fill_err}, 0);
    end else begin
      chk(cwr_valid == 1'b0, "R8", "write suppressed", cwr_valid, 0);
      chk(ifu_fill_err == !src && lsu_fill_err == src, "R8", "error target",
          {ifu_fill_err, lsu_fill_err}, {!src, src});
    end
    @(negedge clk);
    #1;
    chk(cwr_valid == 1'b0, "R3", "write is one cycle", cwr_valid, 0);
    chk(req_ready == 1'b1, "R7", "ready after write", req_ready, 1);
  endtask

  task automatic run_all();
    logic [DW-1:0] d;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_src = 1'b0;
    bus_valid = 1'b0; bus_data = '0; bus_par = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R11", "ready after reset", req_ready, 1);
    chk(!(ifu_fwd_valid || lsu_fwd_valid || cwr_valid || ifu_fill_err || lsu_fill_err),
        "R11", "outputs quiet after reset",
        {ifu_fwd_valid, lsu_fwd_valid, cwr_valid, ifu_fill_err, lsu_fill_err}, 0);

    // R9: stray beats while idle
    @(negedge clk);
    d = 64'hDEAD_BEEF_0123_4567;
    bus_valid = 1'b1; bus_data = d; bus_par = even_par(d);
    #1;
    chk(!(ifu_fwd_valid || lsu_fwd_valid), "R9", "idle beat forwarded",
        {ifu_fwd_valid, lsu_fwd_valid}, 0);
    @(negedge clk);
    bus_valid = 1'b0;
    #1;
    chk(req_ready == 1'b1 && cwr_valid == 1'b0, "R9", "idle beat changed state",
        {req_ready, cwr_valid}, 2'b10);

    // Directed corner cases
    do_fill(32'h1000_0000, 1'b0, -1, 1'b0, 1'b0);  // critical slot 0, fetcher
    do_fill(32'h2000_001C, 1'b1, -1, 1'b0, 1'b0);  // critical slot 3, load/store
    do_fill(32'h3000_0008, 1'b0, -1, 1'b1, 1'b1);  // slot 1, gaps, foreign request R7
    do_fill(32'h4000_0010, 1'b1,  3, 1'b0, 1'b0);  // parity error on last beat R5
    do_fill(32'h5000_0018, 1'b0,  0, 1'b1, 1'b0);  // parity error on first beat R5
    do_fill(32'h6000_0004, 1'b1, -1, 1'b0, 1'b0);  // clean refill after error R8

    // Random refills
    for (int i = 0; i < 24; i++) begin
      logic [AW-1:0] a;
      int bb;
      a  = $urandom();
      bb = ($urandom_range(0, 5) == 0) ? int'($urandom_range(0, NB - 1)) : -1;
      do_fill(a, 1'($urandom_range(0, 1)), bb, 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)));
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_C0DE));
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule